// File: doc/BRIEF.md
# I2C Bus Recovery Controller

This block sits next to an I2C master and frees a bus that a target device has left stuck after being interrupted partway through a transfer. It can be started explicitly, or it starts by itself when a transfer is about to be launched while either bus line reads low. While it works it owns the open-drain SCL and SDA drivers. It waits out a stretched clock, clocks SCL until the target lets go of SDA, and then generates STOP conditions. When it finishes it hands the pins back to the normal controller.

All timing is built from one delay unit of `UNIT_CYCLES` clock cycles. The intended value is about 5 us, which gives roughly 100 kHz signalling. `UNIT_CYCLES` must be at least 4 so that a released line has passed the two-flop synchronizer before it is sampled at the end of a unit. Each recovery ends with a one-cycle `done` pulse. The pulse comes with a success flag and separate stuck-SCL and stuck-SDA flags, and these results stay valid until the next recovery starts. If the port has no recovery pins (`pins_present` low), both lines read high and nothing is ever driven.

Top module: `i2crec_top`

## Requirements
- R1: A start request while both sampled lines are high ends at once: `done` with `ok`=1 in the cycle after the request, zero busy cycles, and no SCL or SDA drive.
- R2: If SCL reads low on entry, it is sampled at the end of each delay unit, up to 10 times. If it reads high by then and SDA is high, the recovery ends with `ok`=1 after exactly that many units.
- R3: If SCL is still low after the 10th poll, the recovery ends with `err_scl`=1 and `ok`=0 after 10 units and generates no clock pulse.
- R4: With SCL high and SDA low, a round releases SCL for one unit. It then gives at most 9 pulses, each with SCL driven low (`scl_oe`=1) for one unit and then released for one unit. SDA is sampled before each pulse, and pulsing stops as soon as SDA reads high.
- R5: Every round ends in a STOP: SDA is driven low (`sda_oe`=1) for one unit and then released for one unit. If both lines then read high, the recovery ends with `ok`=1. SCL and SDA are never driven low together.
- R6: At most 3 rounds are made. After the last STOP, a low SDA sets `err_sda` and a low SCL sets `err_scl`, and either one gives `ok`=0. `ok` is exactly the absence of both errors.
- R7: Drive is open-drain. `scl_oe`/`sda_oe`=1 pulls the line low, and a line being pulled low by this block counts as low. `own` equals `busy`, no line is driven unless `own` is 1, and `own` is 0 in the `done` cycle.
- R8: A transfer request (`xfer_req`) with either sampled line low starts a recovery, and `ctrl_reset` pulses together with its `done`. A transfer request with both lines high has no effect.
- R9: With `pins_present`=0, `line_scl` and `line_sda` read 1. A start request gives `done` with `ok`=1 at once without driving anything, and a transfer request has no effect.
- R10: `done` lasts one cycle. `ok`, `err_scl` and `err_sda` hold their values after `done` until the next recovery starts. After reset all outputs are 0 except `line_scl`/`line_sda`, which are 1 when the pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_present | input | 1 | Recovery pins exist for this port |
| start_req | input | 1 | Start a recovery (single-cycle pulse) |
| xfer_req | input | 1 | A normal transfer is about to start (single-cycle pulse) |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| own | output | 1 | This block owns the pins |
| line_scl | output | 1 | Synchronized SCL level (1 without pins) |
| line_sda | output | 1 | Synchronized SDA level (1 without pins) |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | Recovery finished (one-cycle pulse) |
| ok | output | 1 | Last recovery succeeded |
| err_scl | output | 1 | Last recovery ended with SCL low |
| err_sda | output | 1 | Last recovery ended with SDA low |
| ctrl_reset | output | 1 | Reset the normal controller (with done, transfer-triggered recoveries only) |

## Verification
Every recovery takes a whole number of delay units. `done` therefore rises exactly N*`UNIT_CYCLES` busy cycles after the request is taken, where N is the number of phases the requirements call for: for example 9 units for a release after 3 pulses, and 63 units for a permanently stuck SDA. The bench works out N, the pulse count and the STOP count for each case and queues them. A monitor counts busy cycles, rising `scl_oe` and rising `sda_oe` at the falling clock edge, and compares these counts and the flags in the exact cycle that `done` is high. The target model releases its lines from the same falling-edge counts, so a release always lands inside a known unit, at least two cycles before that unit's sample point.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,    // polling a stretched SCL
    ST_RHI,     // round opening: SCL released for one unit
    ST_PLO,     // pulse: SCL low
    ST_PHI,     // pulse: SCL released
    ST_SLO,     // STOP: SDA low
    ST_SHI,     // STOP: SDA released
    ST_DONE
  } rec_state_e;
endpackage

// File: rtl/i2crec_sync.sv
module i2crec_sync #(
  parameter int          WIDTH     = 2,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RESET_VAL;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RESET_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2crec_tick.sv
module i2crec_tick #(
  parameter int UNIT_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!run)               cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = '0;
    else                    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2crec_fsm.sv
module i2crec_fsm
  import i2crec_pkg::*;
#(
  parameter int SCL_POLLS = 10,
  parameter int PULSES    = 9,
  parameter int ROUNDS    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pins_present,
  input  logic start_req,
  input  logic xfer_req,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic ok,
  output logic err_scl,
  output logic err_sda,
  output logic ctrl_reset
);
  localparam int PW = $clog2(SCL_POLLS + 1);
  localparam int KW = $clog2(PULSES + 1);
  localparam int RW = $clog2(ROUNDS + 1);

  rec_state_e    state_q, state_n;
  logic [PW-1:0] poll_q, poll_n;
  logic [KW-1:0] pulse_q, pulse_n;
  logic [RW-1:0] round_q, round_n;
  logic          ok_q, ok_n, escl_q, escl_n, esda_q, esda_n, xfer_q, xfer_n;
  logic          trig;

  assign trig = start_req || (xfer_req && !(scl_lvl && sda_lvl));

  always_comb begin
    state_n = state_q;
    poll_n  = poll_q;
    pulse_n = pulse_q;
    round_n = round_q;
    ok_n    = ok_q;
    escl_n  = escl_q;
    esda_n  = esda_q;
    xfer_n  = xfer_q;
    unique case (state_q)
      ST_IDLE: if (trig) begin
        xfer_n  = !start_req;
        ok_n    = 1'b0;
        escl_n  = 1'b0;
        esda_n  = 1'b0;
        poll_n  = '0;
        pulse_n = '0;
        round_n = '0;
        if (!pins_present || (scl_lvl && sda_lvl)) begin
          state_n = ST_DONE;
          ok_n    = 1'b1;
        end else if (!scl_lvl) begin
          state_n = ST_WAIT;
        end else begin
          state_n = ST_RHI;
        end
      end
      ST_WAIT: if (tick) begin
        if (scl_lvl) begin
          if (sda_lvl) begin
            state_n = ST_DONE;
            ok_n    = 1'b1;
          end else begin
            state_n = ST_RHI;
          end
        end else if (poll_q == PW'(SCL_POLLS - 1)) begin
          state_n = ST_DONE;
          escl_n  = 1'b1;
        end else begin
          poll_n = poll_q + 1'b1;
        end
      end
      ST_RHI: if (tick) begin
        pulse_n = '0;
        state_n = sda_lvl ? ST_SLO : ST_PLO;
      end
      ST_PLO: if (tick) state_n = ST_PHI;
      ST_PHI: if (tick) begin
        if (sda_lvl || pulse_q == KW'(PULSES - 1)) begin
          state_n = ST_SLO;
        end else begin
          pulse_n = pulse_q + 1'b1;
          state_n = ST_PLO;
        end
      end
      ST_SLO: if (tick) state_n = ST_SHI;
      ST_SHI: if (tick) begin
        if (scl_lvl && sda_lvl) begin
          state_n = ST_DONE;
          ok_n    = 1'b1;
        end else if (round_q == RW'(ROUNDS - 1)) begin
          state_n = ST_DONE;
          escl_n  = !scl_lvl;
          esda_n  = !sda_lvl;
        end else begin
          round_n = round_q + 1'b1;
          state_n = ST_RHI;
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      pulse_q <= '0;
      round_q <= '0;
      ok_q    <= 1'b0;
      escl_q  <= 1'b0;
      esda_q  <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      poll_q  <= poll_n;
      pulse_q <= pulse_n;
      round_q <= round_n;
      ok_q    <= ok_n;
      escl_q  <= escl_n;
      esda_q  <= esda_n;
      xfer_q  <= xfer_n;
    end
  end

  assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done       = (state_q == ST_DONE);
  assign scl_oe     = (state_q == ST_PLO);
  assign sda_oe     = (state_q == ST_SLO);
  assign ok         = ok_q;
  assign err_scl    = escl_q;
  assign err_sda    = esda_q;
  assign ctrl_reset = done && xfer_q;
endmodule

// File: rtl/i2crec_top.sv
module i2crec_top #(
  parameter int UNIT_CYCLES = 500,
  parameter int SYNC_STAGES = 2,
  parameter int SCL_POLLS   = 10,
  parameter int PULSES      = 9,
  parameter int ROUNDS      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pins_present,
  input  logic start_req,
  input  logic xfer_req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic own,
  output logic line_scl,
  output logic line_sda,
  output logic busy,
  output logic done,
  output logic ok,
  output logic err_scl,
  output logic err_sda,
  output logic ctrl_reset
);
  logic [1:0] pin_sync;
  logic       tick, scl_lvl, sda_lvl;

  i2crec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(pin_sync)
  );

  // absent pins look idle
  assign line_scl = !pins_present || pin_sync[0];
  assign line_sda = !pins_present || pin_sync[1];
  // a line this block pulls low is taken as low
  assign scl_lvl  = line_scl && !scl_oe;
  assign sda_lvl  = line_sda && !sda_oe;

  i2crec_tick #(.UNIT_CYCLES(UNIT_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  i2crec_fsm #(.SCL_POLLS(SCL_POLLS), .PULSES(PULSES), .ROUNDS(ROUNDS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pins_present(pins_present),
    .start_req(start_req), .xfer_req(xfer_req),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .ok(ok), .err_scl(err_scl), .err_sda(err_sda), .ctrl_reset(ctrl_reset)
  );

  assign own = busy;
endmodule

// File: rtl/i2crec_chk.sv
module i2crec_chk (
  input logic clk,
  input logic rst_n,
  input logic pins_present,
  input logic scl_oe,
  input logic sda_oe,
  input logic own,
  input logic line_scl,
  input logic line_sda,
  input logic busy,
  input logic done,
  input logic ok,
  input logic err_scl,
  input logic err_sda,
  input logic ctrl_reset
);
  assert_drive_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe || sda_oe) |-> own);
  assert_own_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    own == busy);
  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !own);
  assert_one_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_oe && sda_oe));
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |=> scl_oe);
  assert_stop_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |=> sda_oe);
  assert_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != (err_scl || err_sda)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !busy && !$rose(busy)) |-> $stable(ok));
  assert_reset_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset |-> done);
  assert_nopins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_present |-> (line_scl && line_sda));
endmodule

bind i2crec_top i2crec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pins_present(pins_present),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .own(own),
  .line_scl(line_scl), .line_sda(line_sda), .busy(busy), .done(done),
  .ok(ok), .err_scl(err_scl), .err_sda(err_sda), .ctrl_reset(ctrl_reset)
);

// File: tb/i2crec_top_bench.sv
module i2crec_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int U          = 8;
  localparam int NEVER      = 100000;

  logic clk, rst_n, pins_present, start_req, xfer_req;
  logic scl_oe, sda_oe, own, line_scl, line_sda, busy, done, ok, err_scl, err_sda, ctrl_reset;
  logic scl_hold, sda_hold;
  int   scl_rel, sda_rel;
  int   busy_cyc, pulses, pulse_done, stops, cycles;
  logic prev_scl_oe, prev_sda_oe;
  int   checks, errors;

  typedef struct {
    int   units;
    int   pl;
    int   st;
    logic ok;
    logic es;
    logic ed;
    logic cr;
    string tag;
  } exp_t;
  exp_t sb[$];

  // target model: holds lines low until the released condition is met
  wire scl_pin = !scl_oe && !(scl_hold && (busy_cyc < scl_rel));
  wire sda_pin = !sda_oe && !(sda_hold && (pulse_done < sda_rel));

  i2crec_top #(.UNIT_CYCLES(U)) u_i2crec_top (
    .clk(clk), .rst_n(rst_n), .pins_present(pins_present),
    .start_req(start_req), .xfer_req(xfer_req),
    .scl_in(scl_pin), .sda_in(sda_pin),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own(own),
    .line_scl(line_scl), .line_sda(line_sda), .busy(busy), .done(done),
    .ok(ok), .err_scl(err_scl), .err_sda(err_sda), .ctrl_reset(ctrl_reset)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic chk(input logic cond, input string req, input int act, input int exp_v);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: counts activity and compares at done
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (scl_oe && !prev_scl_oe) pulses++;
      if (!scl_oe && prev_scl_oe) pulse_done++;
      if (sda_oe && !prev_sda_oe) stops++;
      prev_scl_oe = scl_oe;
      prev_sda_oe = sda_oe;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(busy_cyc == e.units * U, {e.tag, " busy cycles"}, busy_cyc, e.units * U);
          chk(pulses == e.pl, {e.tag, " pulses"}, pulses, e.pl);
          chk(stops == e.st, {e.tag, " stops"}, stops, e.st);
          chk(ok == e.ok, {e.tag, " ok"}, int'(ok), int'(e.ok));
          chk(err_scl == e.es, {e.tag, " err_scl"}, int'(err_scl), int'(e.es));
          chk(err_sda == e.ed, {e.tag, " err_sda"}, int'(err_sda), int'(e.ed));
          chk(ctrl_reset == e.cr, {e.tag, " ctrl_reset"}, int'(ctrl_reset), int'(e.cr));
          chk(!own, "R7 own released at done", int'(own), 0);
        end
        busy_cyc   = 0;
        pulses     = 0;
        pulse_done = 0;
        stops      = 0;
      end
    end
  end

  task automatic push(input int units, input int pl, input int st, input logic okv,
                      input logic es, input logic ed, input logic cr, input string tag);
    exp_t e;
    e.units = units; e.pl = pl; e.st = st; e.ok = okv;
    e.es = es; e.ed = ed; e.cr = cr; e.tag = tag;
    sb.push_back(e);
  endtask

  // driver: configure the target, push expectation, fire request, wait for done
  task automatic run_case(input logic use_xfer, input logic sh, input int sr,
                          input logic dh, input int dr,
                          input int units, input int pl, input int st, input logic okv,
                          input logic es, input logic ed, input string tag);
    scl_hold = sh; scl_rel = sr; sda_hold = dh; sda_rel = dr;
    repeat (4) @(negedge clk);
    push(units, pl, st, okv, es, ed, use_xfer, tag);
    if (use_xfer) xfer_req = 1'b1; else start_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0; start_req = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    scl_hold = 1'b0; sda_hold = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0;
    busy_cyc = 0; pulses = 0; pulse_done = 0; stops = 0;
    prev_scl_oe = 1'b0; prev_sda_oe = 1'b0;
    scl_hold = 1'b0; sda_hold = 1'b0; scl_rel = NEVER; sda_rel = NEVER;
    pins_present = 1'b1; start_req = 1'b0; xfer_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !own && !done, "R10 reset busy/own/done", int'({busy, own, done}), 0);
    chk(!ok && !err_scl && !err_sda, "R10 reset flags", int'({ok, err_scl, err_sda}), 0);
    chk(!scl_oe && !sda_oe && !ctrl_reset, "R10 reset drive", int'({scl_oe, sda_oe}), 0);
    chk(line_scl && line_sda, "R10 reset lines", int'({line_scl, line_sda}), 3);

    // R1 idle bus
    run_case(1'b0, 1'b0, 0, 1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b0, "R1 idle");
    // R2 stretched SCL released inside the third unit
    run_case(1'b0, 1'b1, 2*U + 4, 1'b0, 0, 3, 0, 0, 1'b1, 1'b0, 1'b0, "R2 stretch");
    // R3 SCL stuck low
    run_case(1'b0, 1'b1, NEVER, 1'b0, 0, 10, 0, 0, 1'b0, 1'b1, 1'b0, "R3 scl stuck");
    // R4 SDA released after 3 pulses: 1 + 2*3 + 2 units
    run_case(1'b0, 1'b0, 0, 1'b1, 3, 9, 3, 1, 1'b1, 1'b0, 1'b0, "R4 release3");
    // R4/R5 released on the 9th pulse: full round
    run_case(1'b0, 1'b0, 0, 1'b1, 9, 21, 9, 1, 1'b1, 1'b0, 1'b0, "R5 release9");
    // R5 released in second round after 12 pulses: 21 + 1 + 6 + 2
    run_case(1'b0, 1'b0, 0, 1'b1, 12, 30, 12, 2, 1'b1, 1'b0, 1'b0, "R5 round2");
    // R6 SDA stuck: 3 rounds of 21 units
    run_case(1'b0, 1'b0, 0, 1'b1, NEVER, 63, 27, 3, 1'b0, 1'b0, 1'b1, "R6 sda stuck");
    repeat (5) @(negedge clk);
    chk(!ok && err_sda && !err_scl, "R10 flags hold", int'({ok, err_scl, err_sda}), 1);
    // R8 transfer request with SDA low, release after 1 pulse
    run_case(1'b1, 1'b0, 0, 1'b1, 1, 5, 1, 1, 1'b1, 1'b0, 1'b0, "R8 xfer");
    // R8 transfer request on an idle bus: nothing happens
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (busy || done || own) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R8 xfer idle no effect", seen, 0);
    end
    // R9 no pins: physical SCL low but reads high
    pins_present = 1'b0;
    scl_hold = 1'b1; scl_rel = NEVER;
    repeat (4) @(negedge clk);
    chk(line_scl && line_sda, "R9 lines read high", int'({line_scl, line_sda}), 3);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && !own && sb.size() == 0, "R9 xfer ignored", int'(busy), 0);
    run_case(1'b0, 1'b1, NEVER, 1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b0, "R9 nopins start");

    finish_run();
  end
endmodule